// File: doc/BRIEF.md
# Power-Up and Halt Start Sequencer

This block decides where a 16-bit processor begins after power is applied, and what happens after the processor executes a HALT in kernel mode. It reads a set of board straps once, when reset is released. The straps select one of four start modes, four high boot-address bits and a halt action. The block then produces a start PC and PS with a one-cycle load strobe, or it pulses a request to enter the console debugger.

One start mode takes PC and PS from two fixed low memory words. For that mode the block issues word reads over a simple request/acknowledge port, and each read has a bounded wait. After a kernel HALT the block first looks at the bus power-OK input. If power is good, it either requests a trap through vector 4 and sets the halt bit of the CPU error register, or it enters the debugger. If power is not good, it waits for power-OK and then runs the start sequence again.

Top module: `pwr_halt_seq`

## Requirements
- R1: Straps are decoded as follows. Start mode bit i = NOT `mode_strap_fitted[i]`, so 1 means the strap is absent. Boot bit i = `boot_strap_fitted[i]`, so 1 means the strap is present. The halt-action bit = NOT `halt_strap_fitted`, where 1 means trap and 0 means debugger.
- R2: While `rst_n` is low, `busy` is 1 and `load_stb`, `dbg_enter`, `trap_req` and `mem_req` are all 0.
- R3: Mode 0 reads address 0x0014 (octal 24) and then 0x0016 (octal 26). The first read's data becomes `pc_out` and the second read's data becomes `ps_out`, followed by one `load_stb` pulse. The address is held steady while `mem_req` is high.
- R4: `mem_req` stays high for at most TIMEOUT_CYCLES cycles. If no acknowledge arrives during a mode 0 fetch, the block pulses `dbg_enter` with `ps_out` = 0 and issues no `load_stb`.
- R5: Mode 1 pulses `dbg_enter` with `ps_out` = 0 and issues no memory read and no `load_stb`. Once the block is in the debugger, `halt_req` has no effect.
- R6: Mode 2 loads `pc_out` = 0xF600 (octal 173000) and `ps_out` = 0x00E0 (octal 340).
- R7: Mode 3 loads `pc_out` = {boot bits, 12'h000} and `ps_out` = 0x00E0.
- R8: Straps are sampled only on the first clock edge after reset is released. Later strap changes have no effect, including on a restart after a halt.
- R9: On a `halt_req` in the running state, if `pwr_ok` is high on the following cycle and the halt-action bit is 1, the block gives one `trap_req` pulse together with `err_bit7_set`, with `trap_vec` = 0x0004, and no `load_stb`.
- R10: On a `halt_req` with `pwr_ok` high and the halt-action bit at 0, the block pulses `dbg_enter` with `ps_out` = 0.
- R11: On a `halt_req` with `pwr_ok` low, the block issues no pulse and holds `busy` high until `pwr_ok` rises. It then runs the start sequence for the latched mode.
- R12: `load_stb`, `dbg_enter` and `trap_req` are single-cycle pulses and at most one is high at a time. `busy` falls exactly in the cycle one of them is high.
- R13: An acknowledge taken in the last allowed request cycle (cycle TIMEOUT_CYCLES) completes the read. An acknowledge that would come one cycle later arrives too late, and the read times out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_strap_fitted | input | 2 | Start-mode straps, 1 = fitted |
| boot_strap_fitted | input | 4 | Boot address straps for PC[15:12], 1 = fitted |
| halt_strap_fitted | input | 1 | Halt-action strap, 1 = fitted |
| pwr_ok | input | 1 | Bus power-OK |
| halt_req | input | 1 | Pulse: kernel-mode HALT completed |
| mem_req | output | 1 | Memory word read request |
| mem_addr | output | 16 | Read address |
| mem_ack | input | 1 | Read acknowledge, data valid |
| mem_rdata | input | 16 | Read data |
| busy | output | 1 | Sequence in progress |
| load_stb | output | 1 | Pulse: load `pc_out`/`ps_out` |
| pc_out | output | 16 | Start PC |
| ps_out | output | 16 | Start PS |
| dbg_enter | output | 1 | Pulse: enter console debugger |
| trap_req | output | 1 | Pulse: trap request |
| trap_vec | output | 16 | Trap vector address (0x0004) |
| err_bit7_set | output | 1 | Pulse: set bit 7 of CPU error register |

## Verification
The bench builds the block with TIMEOUT_CYCLES = 8 instead of the large default. This puts the read timeout within a few dozen cycles. Acknowledges can then be placed exactly on the last allowed request cycle and one cycle past it. The bench also counts the full request length when memory stays silent.

// File: rtl/pws_pkg.sv
package pws_pkg;

    localparam int WORD_W = 16;

    localparam logic [WORD_W-1:0] PC_VEC_ADDR = 16'o24;
    localparam logic [WORD_W-1:0] PS_VEC_ADDR = 16'o26;
    localparam logic [WORD_W-1:0] STD_BOOT_PC = 16'o173000;
    localparam logic [WORD_W-1:0] BOOT_PS     = 16'o340;
    localparam logic [WORD_W-1:0] HALT_TRAP_VEC = 16'o4;

    typedef enum logic [2:0] {
        ST_SAMPLE,
        ST_DISPATCH,
        ST_FETCH_PC,
        ST_FETCH_PS,
        ST_RUN,
        ST_CONSOLE,
        ST_HALT_CHK,
        ST_PWR_WAIT
    } seq_state_e;

    typedef struct packed {
        logic [1:0] mode;
        logic [3:0] boot_hi;
        logic       halt_trap;
    } strap_cfg_t;

endpackage

// File: rtl/pws_strap_latch.sv
module pws_strap_latch
    import pws_pkg::*;
#(
    parameter int BOOT_BITS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 capture,
    input  logic [1:0]           mode_fitted,
    input  logic [BOOT_BITS-1:0] boot_fitted,
    input  logic                 halt_fitted,
    output strap_cfg_t           cfg
);

    strap_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (capture) begin
            cfg_d.mode      = ~mode_fitted;
            cfg_d.boot_hi   = boot_fitted;
            cfg_d.halt_trap = ~halt_fitted;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;

    // R8
    strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(cfg_q));

endmodule

// File: rtl/pws_mem_reader.sv
module pws_mem_reader
    import pws_pkg::*;
#(
    parameter int TIMEOUT_CYCLES = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] start_addr,
    output logic              mem_req,
    output logic [WORD_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              rd_done,
    output logic              rd_tout,
    output logic [WORD_W-1:0] rd_data
);

    localparam int CNT_W = $clog2(TIMEOUT_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_CYCLES - 1);

    typedef struct packed {
        logic              req;
        logic [WORD_W-1:0] addr;
        logic [CNT_W-1:0]  cnt;
        logic              done;
        logic              tout;
        logic [WORD_W-1:0] data;
    } rd_regs_t;

    rd_regs_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.tout = 1'b0;
        if (!r_q.req) begin
            if (start) begin
                r_d.req  = 1'b1;
                r_d.addr = start_addr;
                r_d.cnt  = '0;
            end
        end else if (mem_ack) begin
            r_d.req  = 1'b0;
            r_d.done = 1'b1;
            r_d.data = mem_rdata;
        end else if (r_q.cnt == CNT_LAST) begin
            r_d.req  = 1'b0;
            r_d.tout = 1'b1;
        end else begin
            r_d.cnt = r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign mem_req  = r_q.req;
    assign mem_addr = r_q.addr;
    assign rd_done  = r_q.done;
    assign rd_tout  = r_q.tout;
    assign rd_data  = r_q.data;

    // R3
    done_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |-> $past(mem_req && mem_ack));

    // R3
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && $past(mem_req)) |-> $stable(mem_addr));

    // R4
    tout_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_tout |-> ($past(mem_req) && !$past(mem_ack)));

endmodule

// File: rtl/pws_seq_core.sv
module pws_seq_core
    import pws_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  strap_cfg_t        cfg,
    input  logic              halt_req,
    input  logic              pwr_ok,
    input  logic              rd_done,
    input  logic              rd_tout,
    input  logic [WORD_W-1:0] rd_data,
    output logic              capture,
    output logic              rd_start,
    output logic [WORD_W-1:0] rd_addr,
    output logic              busy,
    output logic              load_stb,
    output logic              dbg_enter,
    output logic              trap_req,
    output logic [WORD_W-1:0] pc_out,
    output logic [WORD_W-1:0] ps_out
);

    typedef struct packed {
        seq_state_e        state;
        logic [WORD_W-1:0] pc;
        logic [WORD_W-1:0] ps;
        logic              load;
        logic              dbg;
        logic              trap;
        logic              busy;
        logic              start;
        logic [WORD_W-1:0] start_addr;
    } seq_regs_t;

    seq_regs_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.load  = 1'b0;
        s_d.dbg   = 1'b0;
        s_d.trap  = 1'b0;
        s_d.start = 1'b0;
        unique case (s_q.state)
            ST_SAMPLE: begin
                s_d.state = ST_DISPATCH;
            end
            ST_DISPATCH: begin
                unique case (cfg.mode)
                    2'd0: begin
                        s_d.start      = 1'b1;
                        s_d.start_addr = PC_VEC_ADDR;
                        s_d.state      = ST_FETCH_PC;
                    end
                    2'd1: begin
                        s_d.ps    = '0;
                        s_d.dbg   = 1'b1;
                        s_d.busy  = 1'b0;
                        s_d.state = ST_CONSOLE;
                    end
                    2'd2: begin
                        s_d.pc    = STD_BOOT_PC;
                        s_d.ps    = BOOT_PS;
                        s_d.load  = 1'b1;
                        s_d.busy  = 1'b0;
                        s_d.state = ST_RUN;
                    end
                    default: begin
                        s_d.pc    = {cfg.boot_hi, {(WORD_W-4){1'b0}}};
                        s_d.ps    = BOOT_PS;
                        s_d.load  = 1'b1;
                        s_d.busy  = 1'b0;
                        s_d.state = ST_RUN;
                    end
                endcase
            end
            ST_FETCH_PC: begin
                if (rd_done) begin
                    s_d.pc         = rd_data;
                    s_d.start      = 1'b1;
                    s_d.start_addr = PS_VEC_ADDR;
                    s_d.state      = ST_FETCH_PS;
                end else if (rd_tout) begin
                    s_d.ps    = '0;
                    s_d.dbg   = 1'b1;
                    s_d.busy  = 1'b0;
                    s_d.state = ST_CONSOLE;
                end
            end
            ST_FETCH_PS: begin
                if (rd_done) begin
                    s_d.ps    = rd_data;
                    s_d.load  = 1'b1;
                    s_d.busy  = 1'b0;
                    s_d.state = ST_RUN;
                end else if (rd_tout) begin
                    s_d.ps    = '0;
                    s_d.dbg   = 1'b1;
                    s_d.busy  = 1'b0;
                    s_d.state = ST_CONSOLE;
                end
            end
            ST_RUN: begin
                if (halt_req) begin
                    s_d.busy  = 1'b1;
                    s_d.state = ST_HALT_CHK;
                end
            end
            ST_HALT_CHK: begin
                if (!pwr_ok) begin
                    s_d.state = ST_PWR_WAIT;
                end else if (cfg.halt_trap) begin
                    s_d.trap  = 1'b1;
                    s_d.busy  = 1'b0;
                    s_d.state = ST_RUN;
                end else begin
                    s_d.ps    = '0;
                    s_d.dbg   = 1'b1;
                    s_d.busy  = 1'b0;
                    s_d.state = ST_CONSOLE;
                end
            end
            ST_PWR_WAIT: begin
                if (pwr_ok) s_d.state = ST_DISPATCH;
            end
            default: begin
                s_d.state = ST_CONSOLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.state <= ST_SAMPLE;
            s_q.busy  <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign capture   = (s_q.state == ST_SAMPLE);
    assign rd_start  = s_q.start;
    assign rd_addr   = s_q.start_addr;
    assign busy      = s_q.busy;
    assign load_stb  = s_q.load;
    assign dbg_enter = s_q.dbg;
    assign trap_req  = s_q.trap;
    assign pc_out    = s_q.pc;
    assign ps_out    = s_q.ps;

    // R12
    one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({load_stb, dbg_enter, trap_req}));

    // R12
    busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (load_stb || dbg_enter || trap_req));

    // R12
    pulse_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_stb || dbg_enter || trap_req) |-> !busy);

    // R5
    dbg_ps_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_enter |-> (ps_out == '0));

    // R9
    trap_pwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> $past(pwr_ok));

    // R5
    console_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.state == ST_CONSOLE && $past(s_q.state == ST_CONSOLE))
            |-> (!load_stb && !trap_req && !rd_start));

endmodule

// File: rtl/pwr_halt_seq.sv
module pwr_halt_seq
    import pws_pkg::*;
#(
    parameter int TIMEOUT_CYCLES = 256,
    parameter int BOOT_BITS      = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           mode_strap_fitted,
    input  logic [BOOT_BITS-1:0] boot_strap_fitted,
    input  logic                 halt_strap_fitted,
    input  logic                 pwr_ok,
    input  logic                 halt_req,
    output logic                 mem_req,
    output logic [WORD_W-1:0]    mem_addr,
    input  logic                 mem_ack,
    input  logic [WORD_W-1:0]    mem_rdata,
    output logic                 busy,
    output logic                 load_stb,
    output logic [WORD_W-1:0]    pc_out,
    output logic [WORD_W-1:0]    ps_out,
    output logic                 dbg_enter,
    output logic                 trap_req,
    output logic [WORD_W-1:0]    trap_vec,
    output logic                 err_bit7_set
);

    strap_cfg_t        cfg;
    logic              capture;
    logic              rd_start;
    logic [WORD_W-1:0] rd_addr;
    logic              rd_done;
    logic              rd_tout;
    logic [WORD_W-1:0] rd_data;

    pws_strap_latch #(.BOOT_BITS(BOOT_BITS)) u_straps (
        .clk         (clk),
        .rst_n       (rst_n),
        .capture     (capture),
        .mode_fitted (mode_strap_fitted),
        .boot_fitted (boot_strap_fitted),
        .halt_fitted (halt_strap_fitted),
        .cfg         (cfg)
    );

    pws_mem_reader #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_reader (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (rd_start),
        .start_addr (rd_addr),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_ack    (mem_ack),
        .mem_rdata  (mem_rdata),
        .rd_done    (rd_done),
        .rd_tout    (rd_tout),
        .rd_data    (rd_data)
    );

    pws_seq_core u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg       (cfg),
        .halt_req  (halt_req),
        .pwr_ok    (pwr_ok),
        .rd_done   (rd_done),
        .rd_tout   (rd_tout),
        .rd_data   (rd_data),
        .capture   (capture),
        .rd_start  (rd_start),
        .rd_addr   (rd_addr),
        .busy      (busy),
        .load_stb  (load_stb),
        .dbg_enter (dbg_enter),
        .trap_req  (trap_req),
        .pc_out    (pc_out),
        .ps_out    (ps_out)
    );

    assign trap_vec     = HALT_TRAP_VEC;
    assign err_bit7_set = trap_req;

endmodule

// File: tb/pwr_halt_seq_bench.sv
module pwr_halt_seq_bench;

    localparam int TO = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode_strap_fitted = 2'b00;
    logic [3:0]  boot_strap_fitted = 4'h0;
    logic        halt_strap_fitted = 1'b0;
    logic        pwr_ok = 1'b1;
    logic        halt_req = 1'b0;
    logic        mem_req;
    logic [15:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [15:0] mem_rdata = 16'h0;
    logic        busy, load_stb, dbg_enter, trap_req, err_bit7_set;
    logic [15:0] pc_out, ps_out, trap_vec;

    int tests = 0;
    int fails = 0;

    // memory model controls and log
    int          ack_delay = 0;
    logic        mem_mute = 1'b0;
    logic [15:0] pc_word = 16'h0;
    logic [15:0] ps_word = 16'h0;
    int          nreq = 0;
    int          cur = 0;
    int          last_len = 0;
    logic [15:0] addr_log [0:7];

    always #5 clk = ~clk;

    pwr_halt_seq #(.TIMEOUT_CYCLES(TO)) u_pwr_halt_seq (
        .clk(clk), .rst_n(rst_n),
        .mode_strap_fitted(mode_strap_fitted), .boot_strap_fitted(boot_strap_fitted),
        .halt_strap_fitted(halt_strap_fitted), .pwr_ok(pwr_ok), .halt_req(halt_req),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .busy(busy), .load_stb(load_stb), .pc_out(pc_out), .ps_out(ps_out),
        .dbg_enter(dbg_enter), .trap_req(trap_req), .trap_vec(trap_vec),
        .err_bit7_set(err_bit7_set)
    );

    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ack = 1'b0;
            cur = 0;
        end else if (mem_req) begin
            if (cur == 0) begin
                if (nreq < 8) addr_log[nreq] = mem_addr;
                nreq++;
            end
            cur++;
            if (!mem_ack && !mem_mute && (cur - 1) == ack_delay) begin
                mem_ack = 1'b1;
                mem_rdata = (mem_addr == 16'h0014) ? pc_word : ps_word;
            end
        end else begin
            if (cur != 0) last_len = cur;
            cur = 0;
            mem_ack = 1'b0;
        end
    end

    task automatic check(input logic ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // mode m, boot b, halt-action h as bit values; encoded to strap levels per R1
    task automatic do_reset(input logic [1:0] m, input logic [3:0] b, input logic h);
        @(negedge clk);
        rst_n = 1'b0;
        mode_strap_fitted = ~m;
        boot_strap_fitted = b;
        halt_strap_fitted = ~h;
        nreq = 0;
        last_len = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // kind: 0 none, 1 load, 2 dbg, 3 trap
    task automatic wait_event(input int maxc, output int kind);
        kind = 0;
        for (int i = 0; i < maxc; i++) begin
            @(negedge clk);
            if (load_stb || dbg_enter || trap_req) begin
                kind = load_stb ? 1 : (dbg_enter ? 2 : 3);
                check(!busy, "R12 busy low with pulse", {15'd0, busy}, 16'h0);
                return;
            end
        end
    endtask

    task automatic check_pulse_drop();
        @(negedge clk);
        check(!load_stb && !dbg_enter && !trap_req, "R12 pulse one cycle",
              {13'd0, load_stb, dbg_enter, trap_req}, 16'h0);
    endtask

    task automatic pulse_halt();
        @(negedge clk);
        halt_req = 1'b1;
        @(negedge clk);
        halt_req = 1'b0;
    endtask

    task automatic test_reset();
        int k;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(busy === 1'b1, "R2 busy in reset", {15'd0, busy}, 16'h1);
        check(!load_stb && !dbg_enter && !trap_req && !mem_req, "R2 quiet in reset",
              {12'd0, load_stb, dbg_enter, trap_req, mem_req}, 16'h0);
    endtask

    task automatic test_mode2();
        int k;
        do_reset(2'd2, 4'h0, 1'b1);
        wait_event(20, k);
        check(k == 1, "R6 mode2 load", 16'(k), 16'd1);
        check(pc_out == 16'hF600, "R6 mode2 pc", pc_out, 16'hF600);
        check(ps_out == 16'h00E0, "R6 mode2 ps", ps_out, 16'h00E0);
        check_pulse_drop();
        check(nreq == 0, "R6 no mem read", 16'(nreq), 16'd0);
    endtask

    task automatic test_mode3(input logic [3:0] b);
        int k;
        do_reset(2'd3, b, 1'b1);
        wait_event(20, k);
        check(k == 1, "R7 mode3 load", 16'(k), 16'd1);
        check(pc_out == {b, 12'h000}, "R7 R1 mode3 pc", pc_out, {b, 12'h000});
        check(ps_out == 16'h00E0, "R7 mode3 ps", ps_out, 16'h00E0);
        check_pulse_drop();
    endtask

    task automatic test_mode0(input int dly, input logic [15:0] pw, input logic [15:0] sw);
        int k;
        ack_delay = dly; mem_mute = 1'b0; pc_word = pw; ps_word = sw;
        do_reset(2'd0, 4'h0, 1'b1);
        wait_event(100, k);
        check(k == 1, "R3 R13 mode0 load", 16'(k), 16'd1);
        check(pc_out == pw, "R3 mode0 pc", pc_out, pw);
        check(ps_out == sw, "R3 mode0 ps", ps_out, sw);
        check(nreq == 2, "R3 two reads", 16'(nreq), 16'd2);
        check(addr_log[0] == 16'h0014, "R3 first addr", addr_log[0], 16'h0014);
        check(addr_log[1] == 16'h0016, "R3 second addr", addr_log[1], 16'h0016);
        check_pulse_drop();
    endtask

    task automatic test_mode0_timeout(input int dly, input logic mute);
        int k;
        ack_delay = dly; mem_mute = mute;
        do_reset(2'd0, 4'h0, 1'b1);
        wait_event(100, k);
        check(k == 2, "R4 R13 timeout to debugger", 16'(k), 16'd2);
        check(ps_out == 16'h0, "R4 ps cleared", ps_out, 16'h0);
        check(nreq == 1, "R4 single read", 16'(nreq), 16'd1);
        check(last_len == TO, "R4 req length", 16'(last_len), 16'(TO));
        check_pulse_drop();
        mem_mute = 1'b0;
    endtask

    task automatic test_mode1();
        int k;
        do_reset(2'd1, 4'hF, 1'b1);
        wait_event(20, k);
        check(k == 2, "R5 mode1 debugger", 16'(k), 16'd2);
        check(ps_out == 16'h0, "R5 ps cleared", ps_out, 16'h0);
        check(nreq == 0, "R5 no reads", 16'(nreq), 16'd0);
        check_pulse_drop();
        pulse_halt();
        wait_event(20, k);
        check(k == 0, "R5 halt ignored in debugger", 16'(k), 16'd0);
    endtask

    task automatic test_halt_trap();
        int k;
        pwr_ok = 1'b1;
        do_reset(2'd2, 4'h0, 1'b1);
        wait_event(20, k);
        pulse_halt();
        check(busy === 1'b1 || trap_req, "R12 busy during halt", {15'd0, busy}, 16'h1);
        wait_event(20, k);
        check(k == 3, "R9 trap pulse", 16'(k), 16'd3);
        check(trap_vec == 16'h0004, "R9 trap vector", trap_vec, 16'h0004);
        check(err_bit7_set == 1'b1, "R9 error bit set", {15'd0, err_bit7_set}, 16'h1);
        check(pc_out == 16'hF600, "R9 pc untouched", pc_out, 16'hF600);
        check_pulse_drop();
    endtask

    task automatic test_halt_dbg();
        int k;
        pwr_ok = 1'b1;
        do_reset(2'd3, 4'h2, 1'b0);
        wait_event(20, k);
        pulse_halt();
        wait_event(20, k);
        check(k == 2, "R10 halt to debugger", 16'(k), 16'd2);
        check(ps_out == 16'h0, "R10 ps cleared", ps_out, 16'h0);
        check_pulse_drop();
    endtask

    task automatic test_halt_pwr_wait();
        int k;
        pwr_ok = 1'b1;
        do_reset(2'd2, 4'h0, 1'b1);
        wait_event(20, k);
        mode_strap_fitted = ~2'd3;
        boot_strap_fitted = 4'h3;
        pwr_ok = 1'b0;
        pulse_halt();
        wait_event(30, k);
        check(k == 0, "R11 no pulse while power low", 16'(k), 16'd0);
        check(busy === 1'b1, "R11 busy while waiting", {15'd0, busy}, 16'h1);
        pwr_ok = 1'b1;
        wait_event(20, k);
        check(k == 1, "R11 restart load", 16'(k), 16'd1);
        check(pc_out == 16'hF600, "R8 latched mode kept", pc_out, 16'hF600);
        check_pulse_drop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        test_reset();
        test_mode2();
        test_mode3(4'hA);
        test_mode3(4'h5);
        test_mode0(2, 16'h0200, 16'h0053);
        test_mode0(TO - 1, 16'h1234, 16'h00E4);
        test_mode0_timeout(0, 1'b1);
        test_mode0_timeout(TO, 1'b0);
        test_mode1();
        test_halt_trap();
        test_halt_dbg();
        test_halt_pwr_wait();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule